// File: doc/BRIEF.md
# Block Memory Protection Filter

This block sits between one upstream bus master and a downstream memory and decides, for every request, whether it may pass. The memory range is cut into equal-sized blocks. A lookup table holds one bit per block, and that bit marks whether non-secure masters may reach the block. Secure requests always pass. A non-secure request that reaches a block still marked secure is rejected and never shows up on the downstream side.

A rejected request still gets a response upstream. A control bit picks the form of that response: an error response, or read-as-zero with the write dropped. The first rejection after the status was last cleared latches the failing address and the request attributes, and sets a status flag. The flag drives a level interrupt when it is enabled.

Secure software programs the table through a small word-indexed register port. An index register selects which 32-bit table word the data register reaches, and that index can step forward on its own after each data access. Register accesses marked non-secure read as zero and change nothing. Only one request is outstanding at a time.

Top module: `blk_prot_filter`

## Requirements
- R1: A request's block number is address / BLK_BYTES, and it selects bit (block mod 32) of table word (block / 32). A secure request (nsec=0) is always forwarded downstream. A non-secure request is forwarded only when that bit is 1. The bench uses BLK_BYTES=256 and a 15-bit address, which gives 128 blocks in 4 words.
- R2: A rejected request never raises mem_valid_o. When control bit 4 is 0, its response comes in the cycle after acceptance with rdata 0 and err 0. A rejected write reaches no downstream write.
- R3: When control bit 4 is 1, a rejected request's response carries err=1 and rdata 0.
- R4: A rejection while status bit 0 is clear sets that bit, latches the address into INFO_A (offset 7) and latches {mid at bits 8 and up, nsec at bit 1, write at bit 0} into INFO_B (offset 8). Later rejections leave both registers unchanged while the status bit is set.
- R5: irq_o equals status bit 0 AND enable bit 0 (offset 6). Writing 1 to bit 0 of the clear register (offset 5) clears the status bit. Status reads at offset 4.
- R6: Index register (offset 2) selects the table word reached by the data register (offset 3). When control bit 8 is 1, each secure data access advances the index, and after the last word it wraps to 0. A written index above the maximum (offset 1, reads LUT_WORDS-1) is clamped to that maximum. Control sits at offset 0.
- R7: A register access with cfg_nsec_i=1 reads as 0 and changes no register.
- R8: After reset, control, index, table, status and enable are all 0, irq_o is 0 and mem_valid_o is 0.
- R9: When a status clear and a new rejection fall in the same cycle, the status stays set and INFO_A and INFO_B take the new rejection.
- R10: After a request is accepted, req_ready_o stays low until its response has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Upstream request valid |
| req_ready_o | output | 1 | Upstream request accepted this cycle |
| req_addr_i | input | ADDR_W | Request byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data |
| req_nsec_i | input | 1 | 1 = non-secure request |
| req_mid_i | input | MID_W | Master ID |
| rsp_valid_o | output | 1 | Upstream response valid |
| rsp_rdata_o | output | DATA_W | Response read data |
| rsp_err_o | output | 1 | Response error flag |
| mem_valid_o | output | 1 | Downstream request valid |
| mem_ready_i | input | 1 | Downstream ready |
| mem_addr_o | output | ADDR_W | Downstream address |
| mem_write_o | output | 1 | Downstream write flag |
| mem_wdata_o | output | DATA_W | Downstream write data |
| mem_rsp_valid_i | input | 1 | Downstream response valid |
| mem_rdata_i | input | DATA_W | Downstream read data |
| mem_err_i | input | 1 | Downstream error |
| cfg_valid_i | input | 1 | Register access strobe |
| cfg_write_i | input | 1 | Register write flag |
| cfg_addr_i | input | 4 | Register word offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_nsec_i | input | 1 | 1 = non-secure register access |
| cfg_rdata_o | output | 32 | Register read data, same cycle |
| irq_o | output | 1 | Violation interrupt, level |

## Verification
A status-clear write and a fresh rejection can land on the same clock edge. One of them resets the capture state and the other wants to fill it. The bench provokes this by driving a clear write on the register port and a non-secure request to a secure block in the same cycle, while the status is already set. It then reads status and both info registers and expects the status still set, with the info registers holding the new address and attributes rather than the older capture.

// File: rtl/blk_prot_pkg.sv
package blk_prot_pkg;
  typedef enum logic [3:0] {
    REG_CTRL  = 4'd0,
    REG_MAX   = 4'd1,
    REG_IDX   = 4'd2,
    REG_LUT   = 4'd3,
    REG_STAT  = 4'd4,
    REG_CLR   = 4'd5,
    REG_EN    = 4'd6,
    REG_INFOA = 4'd7,
    REG_INFOB = 4'd8
  } reg_sel_e;

  localparam int CTRL_ERR_BIT = 4;
  localparam int CTRL_INC_BIT = 8;
  localparam int INFOB_MID_LSB = 8;
endpackage

// File: rtl/blk_prot_lookup.sv
module blk_prot_lookup #(
  parameter int BLK_NUM_W = 7,
  localparam int NUM_BLKS = 1 << BLK_NUM_W
) (
  input  logic [BLK_NUM_W-1:0] blk_i,
  input  logic                 nsec_i,
  input  logic [NUM_BLKS-1:0]  lut_i,
  output logic                 allow_o
);
  // flat table: word w occupies bits [32w+31:32w], so bit index == block number
  assign allow_o = !nsec_i || lut_i[blk_i];
endmodule

// File: rtl/blk_prot_gate.sv
module blk_prot_gate #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              allow_i,
  input  logic              err_mode_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_err_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              viol_o
);
  logic busy_q, blk_rsp_q, blk_err_q, accept;

  assign req_ready_o = !busy_q && (!allow_i || mem_ready_i);
  assign mem_valid_o = req_valid_i && allow_i && !busy_q;
  assign accept      = req_valid_i && req_ready_o;
  assign viol_o      = accept && !allow_i;

  assign rsp_valid_o = blk_rsp_q || (busy_q && mem_rsp_valid_i);
  assign rsp_rdata_o = blk_rsp_q ? '0 : mem_rdata_i;
  assign rsp_err_o   = blk_rsp_q ? blk_err_q : mem_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      blk_rsp_q <= 1'b0;
      blk_err_q <= 1'b0;
    end else begin
      if (accept)           busy_q <= 1'b1;
      else if (rsp_valid_o) busy_q <= 1'b0;
      blk_rsp_q <= viol_o;
      blk_err_q <= viol_o && err_mode_i;
    end
  end

  a_r2_blocked_rsp_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> rsp_valid_o && rsp_rdata_o == '0);
  a_r3_blocked_rsp_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o && err_mode_i |=> rsp_err_o);
  a_r10_single_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
endmodule

// File: rtl/blk_prot_regs.sv
module blk_prot_regs
  import blk_prot_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int MID_W     = 4,
  parameter int LUT_WORDS = 4,
  localparam int IDX_W    = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_valid_i,
  input  logic                    cfg_write_i,
  input  logic [3:0]              cfg_addr_i,
  input  logic [31:0]             cfg_wdata_i,
  input  logic                    cfg_nsec_i,
  output logic [31:0]             cfg_rdata_o,
  input  logic                    viol_i,
  input  logic [ADDR_W-1:0]       viol_addr_i,
  input  logic                    viol_write_i,
  input  logic                    viol_nsec_i,
  input  logic [MID_W-1:0]        viol_mid_i,
  output logic [LUT_WORDS*32-1:0] lut_o,
  output logic                    err_mode_o,
  output logic                    irq_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(LUT_WORDS - 1);

  logic              err_q, inc_q, stat_q, en_q;
  logic [IDX_W-1:0]  idx_q;
  logic [31:0]       lut_q [LUT_WORDS];
  logic [ADDR_W-1:0] infoa_q;
  logic [31:0]       infob_q;
  logic              sec_acc, sec_wr, lut_acc, clr;

  assign sec_acc = cfg_valid_i && !cfg_nsec_i;
  assign sec_wr  = sec_acc && cfg_write_i;
  assign lut_acc = sec_acc && (cfg_addr_i == REG_LUT);
  assign clr     = sec_wr && (cfg_addr_i == REG_CLR) && cfg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= 1'b0;
      inc_q   <= 1'b0;
      en_q    <= 1'b0;
      stat_q  <= 1'b0;
      idx_q   <= '0;
      infoa_q <= '0;
      infob_q <= '0;
      for (int w = 0; w < LUT_WORDS; w++) lut_q[w] <= '0;
    end else begin
      if (sec_wr) begin
        case (cfg_addr_i)
          REG_CTRL: begin
            err_q <= cfg_wdata_i[CTRL_ERR_BIT];
            inc_q <= cfg_wdata_i[CTRL_INC_BIT];
          end
          REG_IDX: idx_q <= (cfg_wdata_i > 32'(LUT_WORDS - 1)) ? IDX_MAX : cfg_wdata_i[IDX_W-1:0];
          REG_LUT: lut_q[idx_q] <= cfg_wdata_i;
          REG_EN:  en_q <= cfg_wdata_i[0];
          default: ;
        endcase
      end
      if (lut_acc && inc_q) idx_q <= (idx_q == IDX_MAX) ? '0 : idx_q + IDX_W'(1);
      // a new rejection wins over a clear in the same cycle
      stat_q <= (stat_q && !clr) || viol_i;
      if (viol_i && (!stat_q || clr)) begin
        infoa_q <= viol_addr_i;
        infob_q <= 32'({viol_mid_i, 6'b0, viol_nsec_i, viol_write_i});
      end
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (sec_acc) begin
      case (cfg_addr_i)
        REG_CTRL:  cfg_rdata_o = (32'(err_q) << CTRL_ERR_BIT) | (32'(inc_q) << CTRL_INC_BIT);
        REG_MAX:   cfg_rdata_o = 32'(LUT_WORDS - 1);
        REG_IDX:   cfg_rdata_o = 32'(idx_q);
        REG_LUT:   cfg_rdata_o = lut_q[idx_q];
        REG_STAT:  cfg_rdata_o = {31'b0, stat_q};
        REG_EN:    cfg_rdata_o = {31'b0, en_q};
        REG_INFOA: cfg_rdata_o = 32'(infoa_q);
        REG_INFOB: cfg_rdata_o = infob_q;
        default:   cfg_rdata_o = '0;
      endcase
    end
  end

  for (genvar w = 0; w < LUT_WORDS; w++) begin : g_lut_flat
    assign lut_o[w*32 +: 32] = lut_q[w];
  end

  assign err_mode_o = err_q;
  assign irq_o      = stat_q && en_q;

  a_r4_info_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_q && !clr |=> $stable(infoa_q) && $stable(infob_q));
  a_r5_clear_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr && !viol_i |=> !irq_o);
  a_r9_viol_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr && viol_i |=> stat_q);
  a_r6_index_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lut_acc && inc_q && idx_q == IDX_MAX |=> idx_q == '0);
  a_r7_nsec_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i && cfg_write_i && cfg_nsec_i && !viol_i |=>
      $stable(err_q) && $stable(inc_q) && $stable(en_q) && $stable(idx_q) && $stable(stat_q));
endmodule

// File: rtl/blk_prot_filter.sv
module blk_prot_filter #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 32,
  parameter int BLK_BYTES = 256,
  parameter int MID_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              req_nsec_i,
  input  logic [MID_W-1:0]  req_mid_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_err_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_write_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_err_i,
  input  logic              cfg_valid_i,
  input  logic              cfg_write_i,
  input  logic [3:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              cfg_nsec_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              irq_o
);
  localparam int BLK_SHIFT = $clog2(BLK_BYTES);
  localparam int BLK_NUM_W = ADDR_W - BLK_SHIFT;
  localparam int NUM_BLKS  = 1 << BLK_NUM_W;
  localparam int LUT_WORDS = (NUM_BLKS + 31) / 32;

  logic [LUT_WORDS*32-1:0] lut_flat;
  logic allow, err_mode, viol;

  assign mem_addr_o  = req_addr_i;
  assign mem_write_o = req_write_i;
  assign mem_wdata_o = req_wdata_i;

  blk_prot_lookup #(.BLK_NUM_W(BLK_NUM_W)) u_lookup (
    .blk_i   (req_addr_i[ADDR_W-1:BLK_SHIFT]),
    .nsec_i  (req_nsec_i),
    .lut_i   (lut_flat[NUM_BLKS-1:0]),
    .allow_o (allow)
  );

  blk_prot_gate #(.DATA_W(DATA_W)) u_gate (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .allow_i         (allow),
    .err_mode_i      (err_mode),
    .mem_valid_o     (mem_valid_o),
    .mem_ready_i     (mem_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rdata_i     (mem_rdata_i),
    .mem_err_i       (mem_err_i),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_rdata_o     (rsp_rdata_o),
    .rsp_err_o       (rsp_err_o),
    .viol_o          (viol)
  );

  blk_prot_regs #(
    .ADDR_W    (ADDR_W),
    .MID_W     (MID_W),
    .LUT_WORDS (LUT_WORDS)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_valid_i  (cfg_valid_i),
    .cfg_write_i  (cfg_write_i),
    .cfg_addr_i   (cfg_addr_i),
    .cfg_wdata_i  (cfg_wdata_i),
    .cfg_nsec_i   (cfg_nsec_i),
    .cfg_rdata_o  (cfg_rdata_o),
    .viol_i       (viol),
    .viol_addr_i  (req_addr_i),
    .viol_write_i (req_write_i),
    .viol_nsec_i  (req_nsec_i),
    .viol_mid_i   (req_mid_i),
    .lut_o        (lut_flat),
    .err_mode_o   (err_mode),
    .irq_o        (irq_o)
  );
endmodule

// File: tb/blk_prot_filter_bench.sv
module blk_prot_filter_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_nsec = 0;
  logic [14:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mid = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        mem_valid, mem_write;
  logic [14:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rdata = '0;
  logic        cfg_valid = 0, cfg_write = 0, cfg_nsec = 0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        irq;
  int checks = 0, failures = 0, ds_writes = 0;
  bit done = 0;

  always #5 clk = ~clk;

  blk_prot_filter u_blk_prot_filter (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_wdata_i(req_wdata), .req_nsec_i(req_nsec), .req_mid_i(req_mid),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .mem_valid_o(mem_valid), .mem_ready_i(1'b1), .mem_addr_o(mem_addr),
    .mem_write_o(mem_write), .mem_wdata_o(mem_wdata),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_rdata_i(mem_rdata), .mem_err_i(1'b0),
    .cfg_valid_i(cfg_valid), .cfg_write_i(cfg_write), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .cfg_nsec_i(cfg_nsec), .cfg_rdata_o(cfg_rdata), .irq_o(irq)
  );

  // memory model: answers one cycle after acceptance with an address pattern
  always @(posedge clk) begin
    mem_rsp_valid <= mem_valid;
    mem_rdata     <= 32'hC0DE_0000 | 32'(mem_addr);
    if (mem_valid && mem_write) ds_writes <= ds_writes + 1;
  end

  // entry: [17:3] addr, [2] write, [1] nsec, [0] expected forward
  localparam logic [17:0] VEC [10] = '{
    {15'h0000, 1'b0, 1'b0, 1'b1},
    {15'h0400, 1'b0, 1'b1, 1'b1},
    {15'h07FF, 1'b1, 1'b1, 1'b1},
    {15'h0812, 1'b0, 1'b1, 1'b0},
    {15'h2000, 1'b0, 1'b1, 1'b1},
    {15'h3F04, 1'b0, 1'b1, 1'b1},
    {15'h3E00, 1'b1, 1'b1, 1'b0},
    {15'h7F00, 1'b0, 1'b1, 1'b1},
    {15'h7E00, 1'b1, 1'b0, 1'b1},
    {15'h00FF, 1'b0, 1'b1, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic w, input logic [3:0] a, input logic [31:0] d,
                     input logic ns, output logic [31:0] rd);
    @(negedge clk);
    cfg_valid = 1; cfg_write = w; cfg_addr = a; cfg_wdata = d; cfg_nsec = ns;
    #1 rd = cfg_rdata;
    @(negedge clk);
    cfg_valid = 0; cfg_write = 0; cfg_nsec = 0;
  endtask

  task automatic txn(input logic [14:0] a, input logic w, input logic ns, input logic [3:0] mid,
                     output logic fwd, output logic v, output logic [31:0] d,
                     output logic e, output logic rdy);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; req_nsec = ns; req_mid = mid;
    req_wdata = 32'h1234_0000 | 32'(a);
    #1 fwd = mem_valid;
    @(negedge clk);
    req_valid = 0;
    v = rsp_valid; d = rsp_rdata; e = rsp_err; rdy = req_ready;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, d;
    logic fwd, v, e, rdy;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R8 irq", irq, 0);
    check("R8 mem_valid", mem_valid, 0);
    cfg(0, 4'd0, 0, 0, rd); check("R8 ctrl", rd, 0);
    cfg(0, 4'd2, 0, 0, rd); check("R8 idx", rd, 0);
    cfg(0, 4'd3, 0, 0, rd); check("R8 lut", rd, 0);
    cfg(0, 4'd4, 0, 0, rd); check("R8 stat", rd, 0);
    cfg(0, 4'd1, 0, 0, rd); check("R6 max", rd, 3);

    // table fill with auto-increment
    cfg(1, 4'd0, 32'h100, 0, rd);
    cfg(1, 4'd2, 0, 0, rd);
    cfg(1, 4'd3, 32'h0000_00F0, 0, rd);
    cfg(1, 4'd3, 32'h8000_0001, 0, rd);
    cfg(1, 4'd3, 32'h0000_0000, 0, rd);
    cfg(1, 4'd3, 32'h8000_0000, 0, rd);
    cfg(0, 4'd2, 0, 0, rd); check("R6 wrap", rd, 0);
    cfg(0, 4'd3, 0, 0, rd); check("R6 word0", rd, 32'h0000_00F0);
    cfg(0, 4'd3, 0, 0, rd); check("R6 word1", rd, 32'h8000_0001);
    cfg(0, 4'd2, 0, 0, rd); check("R6 inc on read", rd, 2);
    cfg(1, 4'd2, 9, 0, rd);
    cfg(0, 4'd2, 0, 0, rd); check("R6 clamp", rd, 3);
    cfg(1, 4'd0, 0, 0, rd);

    // non-secure register access
    cfg(1, 4'd0, 32'h110, 1, rd);
    cfg(1, 4'd6, 1, 1, rd);
    cfg(0, 4'd3, 0, 1, rd); check("R7 nsec read", rd, 0);
    cfg(0, 4'd0, 0, 0, rd); check("R7 ctrl kept", rd, 0);
    cfg(0, 4'd6, 0, 0, rd); check("R7 en kept", rd, 0);

    // table-driven traffic in RAZ/WI mode
    for (int i = 0; i < 10; i++) begin
      txn(VEC[i][17:3], VEC[i][2], VEC[i][1], 4'(i), fwd, v, d, e, rdy);
      check($sformatf("R1 fwd v%0d", i), fwd, VEC[i][0]);
      check($sformatf("R10 busy v%0d", i), rdy, 0);
      check($sformatf("R2 rsp v%0d", i), v, 1);
      if (!VEC[i][0]) begin
        check($sformatf("R2 zero v%0d", i), d, 0);
        check($sformatf("R2 noerr v%0d", i), e, 0);
      end else if (!VEC[i][2]) begin
        check($sformatf("R1 data v%0d", i), d, 32'hC0DE_0000 | 32'(VEC[i][17:3]));
      end
    end
    check("R2 write dropped", ds_writes, 2);
    cfg(0, 4'd4, 0, 0, rd); check("R4 stat", rd, 1);
    cfg(0, 4'd7, 0, 0, rd); check("R4 infoA first", rd, 32'h0812);
    cfg(0, 4'd8, 0, 0, rd); check("R4 infoB first", rd, 32'h302);
    check("R5 irq disabled", irq, 0);
    cfg(1, 4'd6, 1, 0, rd);
    #1 check("R5 irq enabled", irq, 1);
    cfg(1, 4'd5, 1, 0, rd);
    #1 check("R5 irq cleared", irq, 0);
    cfg(0, 4'd4, 0, 0, rd); check("R5 stat cleared", rd, 0);

    // error response mode
    cfg(1, 4'd0, 32'h10, 0, rd);
    txn(15'h1000, 1, 1, 4'h9, fwd, v, d, e, rdy);
    check("R3 no fwd", fwd, 0);
    check("R3 err", e, 1);
    check("R3 data", d, 0);
    cfg(0, 4'd7, 0, 0, rd); check("R4 infoA new", rd, 32'h1000);
    cfg(0, 4'd8, 0, 0, rd); check("R4 infoB new", rd, 32'h903);
    check("R5 irq set", irq, 1);

    // clear and rejection on the same edge
    @(negedge clk);
    cfg_valid = 1; cfg_write = 1; cfg_addr = 4'd5; cfg_wdata = 1; cfg_nsec = 0;
    req_valid = 1; req_addr = 15'h5000; req_write = 0; req_nsec = 1; req_mid = 4'hA;
    @(negedge clk);
    cfg_valid = 0; cfg_write = 0; req_valid = 0;
    check("R9 rsp", rsp_valid, 1);
    check("R9 err", rsp_err, 1);
    @(negedge clk);
    cfg(0, 4'd4, 0, 0, rd); check("R9 stat held", rd, 1);
    cfg(0, 4'd7, 0, 0, rd); check("R9 infoA", rd, 32'h5000);
    cfg(0, 4'd8, 0, 0, rd); check("R9 infoB", rd, 32'hA02);
    check("R9 irq", irq, 1);

    // table update opens block 0
    cfg(1, 4'd0, 0, 0, rd);
    cfg(1, 4'd2, 0, 0, rd);
    cfg(1, 4'd3, 32'h0000_00F1, 0, rd);
    txn(15'h0010, 0, 1, 4'h1, fwd, v, d, e, rdy);
    check("R1 reopened fwd", fwd, 1);
    check("R1 reopened data", d, 32'hC0DE_0010);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule